// File: doc/BRIEF.md
# Acquisition Mode and Status Controller

This block is the operating-mode controller that sits above a current-input converter interface. It synchronises and debounces the front-panel buttons and switches. It holds pending settings (full-scale-range code, diagnostic test flag and acquisition mode) and applies them only when a global reset is accepted. It sequences the converter through a power-up hold, a configuration run and measurement. It also decides which completed measurement frames are forwarded downstream.

In continuous mode every frame that completes while measuring is forwarded. In triggered mode a trigger press arms a one-shot, and only the next frame to complete is forwarded. A pause press idles every control and status output until the next global reset. Two state LEDs show the phase. A three-colour LED shows configuration success, configuration or timing errors, and FIFO misuse, in priority order. The error colours are sticky.

Top module: `acq_mode_ctrl`

## Requirements
- R1: Each button and switch passes a two-stage synchroniser and is accepted only after its synchronised level has differed from the accepted level for DEB_CYCLES consecutive cycles. Shorter glitches are discarded, and a button acts once, on the rising edge of its accepted level.
- R2: An accepted test-button press toggles a pending test flag, which `led_test` shows. `cfg_test` takes the pending value only when a global reset is accepted.
- R3: `cfg_fsr` and the acquisition mode (`sw_trig_mode`, 1 = triggered) take the accepted switch levels only when a global reset is accepted. After power-on reset `cfg_fsr` equals DEF_FSR, `cfg_test` is 0 and the mode is continuous.
- R4: After power-on reset or an accepted global reset, `adc_rst` is high for exactly PWR_CYCLES cycles. `cfg_start` is then high for one cycle, at the start of the configuration phase.
- R5: In the configuration phase, `cfg_pass` moves the block to measuring and `cfg_fail` moves it to idle. From idle it does not measure until a global reset.
- R6: `led_cfg` is lit during power-up, configuration and idle, `led_meas` is lit while measuring, and the two are never lit together.
- R7: In continuous mode, `frame_fwd` equals `frame_done` in every measuring cycle and is 0 outside measuring.
- R8: In triggered mode, an accepted trigger press arms the block. Only the first `frame_done` seen while measuring after the arming edge is forwarded, and that frame disarms it. A global reset disarms it.
- R9: `rgb` is {red, green, blue}, at most one bit set. Blue (FIFO read-when-empty or write-when-full) beats red (configuration fail, or an integration time that is too short). Red beats green (configuration pass). The value is 3'b000 when none has occurred.
- R10: The colour flags are sticky and are cleared only by power-on reset or an accepted global reset.
- R11: An accepted pause press drives `adc_rst`, `cfg_start`, `frame_fwd`, `led_cfg`, `led_meas`, `led_test` and `rgb` to 0 until a global reset is accepted. While paused, the status inputs, frames, trigger and test presses are ignored. A global reset accepted in the same cycle as a pause wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| btn_greset | input | 1 | Global reset button, raw |
| btn_test | input | 1 | Test-mode toggle button, raw |
| btn_pause | input | 1 | Pause button, raw |
| btn_trig | input | 1 | Trigger button, raw |
| sw_fsr | input | 3 | Full-scale-range switches, raw |
| sw_trig_mode | input | 1 | Acquisition mode switch, 1 = triggered |
| cfg_pass | input | 1 | Configuration verifier reports a match |
| cfg_fail | input | 1 | Configuration verifier reports a mismatch |
| int_short | input | 1 | Integration time too short |
| fifo_rd_empty | input | 1 | FIFO read while empty |
| fifo_wr_full | input | 1 | FIFO written while full |
| frame_done | input | 1 | One-cycle pulse: a measurement frame completed |
| adc_rst | output | 1 | Converter reset request (power-up hold) |
| cfg_start | output | 1 | One-cycle configuration start request |
| cfg_fsr | output | 3 | Applied full-scale-range code |
| cfg_test | output | 1 | Applied diagnostic test flag |
| frame_fwd | output | 1 | Forward the frame completing this cycle |
| led_cfg | output | 1 | State LED: power-up, idle or configuration |
| led_meas | output | 1 | State LED: measuring |
| led_test | output | 1 | Pending test flag indicator |
| rgb | output | 3 | Status colour {red, green, blue} |

## Verification
The bench builds the block with DEB_CYCLES = 3 and PWR_CYCLES = 5, so a whole press, an accepted reset and a full power-up then configuration sequence take only a handful of cycles. This lets many global resets, glitches shorter than the debounce window, trigger arming across several frames and pause episodes fit in one short run. A behavioural model that keeps each raw input's history as a bit vector is compared against every output on every cycle.

// File: rtl/acq_pkg.sv
package acq_pkg;

  typedef enum logic [2:0] {
    PH_PWRUP = 3'd0,
    PH_CFG   = 3'd1,
    PH_MEAS  = 3'd2,
    PH_IDLE  = 3'd3,
    PH_PAUSE = 3'd4
  } phase_e;

  // raw input channel positions
  localparam int CH_GRST  = 0;
  localparam int CH_TEST  = 1;
  localparam int CH_PAUSE = 2;
  localparam int CH_TRIG  = 3;
  localparam int CH_FSR0  = 4;
  localparam int CH_MODE  = 7;
  localparam int N_CH     = 8;

  // colour choice, blue over red over green; result is {r,g,b}
  function automatic logic [2:0] rgb_pick(input logic blue, input logic red,
                                          input logic green);
    if (blue)       return 3'b001;
    else if (red)   return 3'b100;
    else if (green) return 3'b010;
    else            return 3'b000;
  endfunction

endpackage

// File: rtl/acq_debounce.sv
module acq_debounce #(
  parameter int DEB_CYCLES = 1200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level,
  output logic rise
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic          s1, s2, lvl_q;
  logic [CW-1:0] cnt;
  logic          accept;

  assign accept = (s2 != lvl_q) && (cnt == CW'(DEB_CYCLES - 1));
  assign rise   = accept && s2;
  assign level  = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      lvl_q <= 1'b0;
      cnt   <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (s2 == lvl_q) begin
        cnt <= '0;
      end else if (accept) begin
        lvl_q <= s2;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/acq_phase_fsm.sv
module acq_phase_fsm
  import acq_pkg::*;
#(
  parameter int PWR_CYCLES = 360
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   gr_rise,
  input  logic   pause_rise,
  input  logic   cfg_pass,
  input  logic   cfg_fail,
  output phase_e phase,
  output logic   cfg_start
);
  localparam int PW = $clog2(PWR_CYCLES + 1);

  logic [PW-1:0] tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_PWRUP;
      tmr       <= '0;
      cfg_start <= 1'b0;
    end else begin
      cfg_start <= 1'b0;
      if (gr_rise) begin
        phase <= PH_PWRUP;
        tmr   <= '0;
      end else if (pause_rise && phase != PH_PAUSE) begin
        phase <= PH_PAUSE;
      end else begin
        case (phase)
          PH_PWRUP: begin
            if (tmr == PW'(PWR_CYCLES - 1)) begin
              phase     <= PH_CFG;
              cfg_start <= 1'b1;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          PH_CFG: begin
            if (cfg_pass)      phase <= PH_MEAS;
            else if (cfg_fail) phase <= PH_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/acq_status_led.sv
module acq_status_led
  import acq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       live,
  input  logic       set_green,
  input  logic       set_red,
  input  logic       set_blue,
  output logic [2:0] rgb
);
  logic f_g, f_r, f_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_g <= 1'b0;
      f_r <= 1'b0;
      f_b <= 1'b0;
    end else if (clr) begin
      f_g <= 1'b0;
      f_r <= 1'b0;
      f_b <= 1'b0;
    end else if (live) begin
      f_g <= f_g | set_green;
      f_r <= f_r | set_red;
      f_b <= f_b | set_blue;
    end
  end

  assign rgb = live ? rgb_pick(f_b, f_r, f_g) : 3'b000;
endmodule

// File: rtl/acq_mode_ctrl.sv
module acq_mode_ctrl
  import acq_pkg::*;
#(
  parameter int         DEB_CYCLES = 1200000,
  parameter int         PWR_CYCLES = 360,
  parameter logic [2:0] DEF_FSR    = 3'b111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_greset,
  input  logic       btn_test,
  input  logic       btn_pause,
  input  logic       btn_trig,
  input  logic [2:0] sw_fsr,
  input  logic       sw_trig_mode,
  input  logic       cfg_pass,
  input  logic       cfg_fail,
  input  logic       int_short,
  input  logic       fifo_rd_empty,
  input  logic       fifo_wr_full,
  input  logic       frame_done,
  output logic       adc_rst,
  output logic       cfg_start,
  output logic [2:0] cfg_fsr,
  output logic       cfg_test,
  output logic       frame_fwd,
  output logic       led_cfg,
  output logic       led_meas,
  output logic       led_test,
  output logic [2:0] rgb
);
  logic [N_CH-1:0] raw_in, db_lvl, db_rise;

  assign raw_in = {sw_trig_mode, sw_fsr, btn_trig, btn_pause, btn_test, btn_greset};

  for (genvar c = 0; c < N_CH; c++) begin : g_deb
    acq_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_in[c]),
      .level (db_lvl[c]),
      .rise  (db_rise[c])
    );
  end

  // named internal events
  logic gr_rise, test_rise, pause_rise, trig_rise;
  logic paused, measuring, fwd_take;
  assign gr_rise    = db_rise[CH_GRST];
  assign test_rise  = db_rise[CH_TEST];
  assign pause_rise = db_rise[CH_PAUSE];
  assign trig_rise  = db_rise[CH_TRIG];

  phase_e phase;

  acq_phase_fsm #(.PWR_CYCLES(PWR_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .gr_rise    (gr_rise),
    .pause_rise (pause_rise),
    .cfg_pass   (cfg_pass),
    .cfg_fail   (cfg_fail),
    .phase      (phase),
    .cfg_start  (cfg_start)
  );

  assign paused    = (phase == PH_PAUSE);
  assign measuring = (phase == PH_MEAS);

  // staged and applied settings, trigger one-shot
  logic pend_test, app_trig, armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_fsr   <= DEF_FSR;
      cfg_test  <= 1'b0;
      app_trig  <= 1'b0;
      pend_test <= 1'b0;
      armed     <= 1'b0;
    end else begin
      if (test_rise && !paused) pend_test <= ~pend_test;
      if (gr_rise) begin
        cfg_fsr  <= db_lvl[CH_FSR0 +: 3];
        cfg_test <= pend_test;
        app_trig <= db_lvl[CH_MODE];
        armed    <= 1'b0;
      end else if (!paused) begin
        if (trig_rise)     armed <= 1'b1;
        else if (fwd_take) armed <= 1'b0;
      end
    end
  end

  assign fwd_take  = measuring && frame_done && armed;
  assign frame_fwd = measuring && frame_done && (!app_trig || armed);

  acq_status_led u_led (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (gr_rise),
    .live      (!paused),
    .set_green (cfg_pass && phase == PH_CFG),
    .set_red   ((cfg_fail && phase == PH_CFG) || int_short),
    .set_blue  (fifo_rd_empty || fifo_wr_full),
    .rgb       (rgb)
  );

  assign adc_rst  = (phase == PH_PWRUP);
  assign led_cfg  = (phase == PH_PWRUP) || (phase == PH_CFG) || (phase == PH_IDLE);
  assign led_meas = measuring;
  assign led_test = pend_test && !paused;
endmodule

// File: rtl/acq_mode_ctrl_chk.sv
module acq_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       led_cfg,
  input logic       led_meas,
  input logic       led_test,
  input logic [2:0] rgb,
  input logic       cfg_start,
  input logic       adc_rst,
  input logic       frame_fwd,
  input logic       frame_done,
  input logic       cfg_test,
  input logic       paused,
  input logic       gr_rise,
  input logic       pause_rise,
  input logic [7:0] db_lvl,
  input logic [7:0] db_rise
);
  // R6
  a_r6_led_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(led_cfg && led_meas));

  // R9
  a_r9_one_colour: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rgb));

  // R4
  a_r4_start_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_start |-> $past(adc_rst));

  // R7
  a_r7_fwd_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frame_fwd |-> (frame_done && led_meas));

  // R10
  a_r10_blue_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb[0] && !gr_rise && !pause_rise) |=> rgb[0]);

  // R2
  a_r2_test_held: assert property (@(posedge clk) disable iff (!rst_n)
    !gr_rise |=> $stable(cfg_test));

  // R11
  a_r11_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> (rgb == 3'b000 && !frame_fwd && !cfg_start && !adc_rst
                && !led_cfg && !led_meas && !led_test));

  // R1
  a_r1_rise_to_level: assert property (@(posedge clk) disable iff (!rst_n)
    (db_rise != 8'h00) |=> ((db_lvl & $past(db_rise)) == $past(db_rise)));
endmodule

bind acq_mode_ctrl acq_mode_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .led_cfg    (led_cfg),
  .led_meas   (led_meas),
  .led_test   (led_test),
  .rgb        (rgb),
  .cfg_start  (cfg_start),
  .adc_rst    (adc_rst),
  .frame_fwd  (frame_fwd),
  .frame_done (frame_done),
  .cfg_test   (cfg_test),
  .paused     (paused),
  .gr_rise    (gr_rise),
  .pause_rise (pause_rise),
  .db_lvl     (db_lvl),
  .db_rise    (db_rise)
);

// File: tb/acq_mode_ctrl_tb.sv
module acq_mode_ctrl_tb;
  localparam int PERIOD = 10;
  localparam int DEB    = 3;
  localparam int PWR    = 5;
  localparam logic [2:0] DFSR = 3'b111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] raw = '0;   // {mode, fsr[2:0], trig, pause, test, greset}
  logic cfg_pass = 0, cfg_fail = 0, int_short = 0;
  logic fifo_rd_empty = 0, fifo_wr_full = 0, frame_done = 0;

  logic adc_rst, cfg_start, cfg_test, frame_fwd, led_cfg, led_meas, led_test;
  logic [2:0] cfg_fsr, rgb;

  always #(PERIOD/2) clk = ~clk;

  acq_mode_ctrl #(.DEB_CYCLES(DEB), .PWR_CYCLES(PWR), .DEF_FSR(DFSR)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .btn_greset(raw[0]), .btn_test(raw[1]), .btn_pause(raw[2]), .btn_trig(raw[3]),
    .sw_fsr(raw[6:4]), .sw_trig_mode(raw[7]),
    .cfg_pass(cfg_pass), .cfg_fail(cfg_fail), .int_short(int_short),
    .fifo_rd_empty(fifo_rd_empty), .fifo_wr_full(fifo_wr_full),
    .frame_done(frame_done),
    .adc_rst(adc_rst), .cfg_start(cfg_start), .cfg_fsr(cfg_fsr), .cfg_test(cfg_test),
    .frame_fwd(frame_fwd), .led_cfg(led_cfg), .led_meas(led_meas),
    .led_test(led_test), .rgb(rgb)
  );

  // ---------------- behavioural reference ----------------
  // phases: 0 power-up, 1 config, 2 measure, 3 idle, 4 paused
  int         m_ph, m_cnt;
  bit         m_start, m_pend, m_test, m_trig, m_armed, m_g, m_r, m_b;
  bit  [2:0]  m_fsr;
  bit  [7:0]  m_stab;
  bit  [31:0] m_hist [8];

  always @(posedge clk) begin : model
    bit [7:0] rise, nstab;
    bit same;
    int oph;
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_start = 0; m_pend = 0; m_test = 0; m_trig = 0;
      m_armed = 0; m_g = 0; m_r = 0; m_b = 0; m_fsr = DFSR; m_stab = '0;
      for (int c = 0; c < 8; c++) m_hist[c] = '0;
    end else begin
      for (int c = 0; c < 8; c++) begin
        same = 1;
        for (int k = 1; k <= DEB; k++) if (m_hist[c][k] == m_stab[c]) same = 0;
        rise[c]  = same && !m_stab[c];
        nstab[c] = same ? !m_stab[c] : m_stab[c];
      end
      oph = m_ph;
      if (rise[1] && oph != 4) m_pend = !m_pend;
      if (rise[0]) begin
        m_fsr = m_stab[6:4]; m_test = (rise[1] && oph != 4) ? !m_pend : m_pend;
        m_trig = m_stab[7]; m_armed = 0; m_g = 0; m_r = 0; m_b = 0;
      end else if (oph != 4) begin
        if (rise[3]) m_armed = 1;
        else if (oph == 2 && frame_done && m_armed) m_armed = 0;
        if (oph == 1 && cfg_pass) m_g = 1;
        if ((oph == 1 && cfg_fail) || int_short) m_r = 1;
        if (fifo_rd_empty || fifo_wr_full) m_b = 1;
      end
      m_start = 0;
      if (rise[0]) begin
        m_ph = 0; m_cnt = 0;
      end else if (rise[2] && oph != 4) begin
        m_ph = 4;
      end else if (oph == 0) begin
        if (m_cnt == PWR - 1) begin m_ph = 1; m_start = 1; end
        else m_cnt++;
      end else if (oph == 1) begin
        if (cfg_pass) m_ph = 2;
        else if (cfg_fail) m_ph = 3;
      end
      for (int c = 0; c < 8; c++) m_hist[c] = {m_hist[c][30:0], raw[c]};
      m_stab = nstab;
    end
  end

  // ---------------- comparison ----------------
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin : cmp
      bit p, exp_fwd;
      bit [2:0] exp_rgb;
      p = (m_ph == 4);
      exp_fwd = (m_ph == 2) && frame_done && (!m_trig || m_armed);
      exp_rgb = p ? 3'b000 : m_b ? 3'b001 : m_r ? 3'b100 : m_g ? 3'b010 : 3'b000;
      check("R4 adc_rst",       adc_rst,   (m_ph == 0));
      check("R4 cfg_start",     cfg_start, m_start);
      check("R3 cfg_fsr",       cfg_fsr,   m_fsr);
      check("R2 cfg_test",      cfg_test,  m_test);
      check("R1 R2 led_test",   led_test,  m_pend && !p);
      check("R7 R8 frame_fwd",  frame_fwd, exp_fwd);
      check("R6 led_cfg",       led_cfg,   (m_ph == 0 || m_ph == 1 || m_ph == 3));
      check("R5 R6 led_meas",   led_meas,  (m_ph == 2));
      check("R9 R10 rgb",       rgb,       exp_rgb);
      if (p) check("R11 paused outputs quiet",
                   {adc_rst, cfg_start, frame_fwd, led_cfg, led_meas, led_test, rgb},
                   0);
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input int c, input int hold);
    raw[c] = 1'b1; cyc(hold); raw[c] = 1'b0; cyc(DEB + 4);
  endtask

  task automatic pulse_frame();
    frame_done = 1'b1; cyc(1); frame_done = 1'b0; cyc(2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    // reset state and power-up hold (R4, R3)
    cyc(PWR + 3);
    cfg_pass = 1; cyc(1); cfg_pass = 0; cyc(2);          // R5 pass, green
    repeat (3) pulse_frame();                            // R7 continuous
    // glitch shorter than window is discarded (R1)
    press(1, DEB - 1);
    press(1, DEB + 1);                                   // R2 pending toggles
    raw[6:4] = 3'b010; raw[7] = 1'b1; cyc(DEB + 4);      // R3 staged only
    pulse_frame();
    // global reset applies staged settings (R3, R2, R10)
    press(0, DEB + 2);
    cyc(PWR + 2);
    cfg_pass = 1; cyc(1); cfg_pass = 0; cyc(2);
    // triggered mode (R8)
    repeat (2) pulse_frame();
    press(3, DEB + 1);
    repeat (3) pulse_frame();
    press(3, DEB + 2);
    pulse_frame();
    // colour priority and stickiness (R9, R10)
    int_short = 1; cyc(1); int_short = 0; cyc(3);
    fifo_wr_full = 1; cyc(1); fifo_wr_full = 0; cyc(3);
    fifo_rd_empty = 1; cyc(1); fifo_rd_empty = 0; cyc(2);
    // pause (R11)
    press(2, DEB + 1);
    press(3, DEB + 1);
    press(1, DEB + 1);
    int_short = 1; frame_done = 1; cyc(2); int_short = 0; frame_done = 0; cyc(2);
    raw[7] = 1'b0; raw[6:4] = 3'b101; cyc(DEB + 4);
    press(0, DEB + 1);                                   // leaves pause
    cyc(PWR + 2);
    cfg_fail = 1; cyc(1); cfg_fail = 0; cyc(3);          // R5 idle, red
    cfg_pass = 1; cyc(1); cfg_pass = 0; cyc(2);          // ignored in idle
    pulse_frame();
    // reconfigure, continuous, pass
    press(0, DEB + 1);
    cyc(PWR + 1);
    cfg_pass = 1; cyc(1); cfg_pass = 0; cyc(2);
    repeat (2) pulse_frame();
    cyc(5);
    finish_run();
  end
endmodule